// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin-Change Flags

This block is one general-purpose I/O port of configurable width (eight bits by default). Software sees five byte-wide registers on a simple synchronous register bus. A direction register decides, bit by bit, whether a pin drives or listens. A data register supplies the driven level on output pins and the pull-up request on input pins. A read-only pin register returns the synchronized pad level. A change-mask register and a change-flag register provide pin-change interrupts. On the pad side every bit has a drive value, a drive enable and a pull-up enable, and the raw pad level comes back in. Pad electricals are outside the block; the pull-up is only a request toward the pad.

The raw pad level passes through a two-flop synchronizer. By default the first flop samples on the falling clock edge and the second on the rising edge, so a pad edge reaches the pin register 0.5 to 1.5 clock periods later. A parameter picks a conventional pair of rising-edge flops instead. The pin register always shows the pad, including pins the port drives itself. A write to a pin's data bit can therefore raise that pin's change flag, and firmware can use this to raise an interrupt. A write of ones to the pin register address inverts the matching data bits. A global pull-up disable input suppresses every pull-up request.

Top module: `gpio_bank`

## Requirements
- R1: The reset input is synchronous and active high. It clears the direction (address 1), data (address 2), change-mask (address 3) and change-flag (address 4) registers, so every pad_oe, pad_pu and irq output is 0 after reset.
- R2: For a bit whose direction bit is 1, pad_oe is 1 and pad_out equals that bit of the data register. A data write takes effect on the rising edge that accepts it.
- R3: For a bit whose direction bit is 0, pad_oe is 0. While pull_disable is low, pad_pu equals that bit of the data register: 1 requests the pull-up and 0 leaves the pin floating.
- R4: A write to address 0 inverts every data-register bit whose write-data bit is 1 and leaves the bits written 0 unchanged, whatever the direction bits are. The write cannot change the pin register.
- R5: While pull_disable is high, every pad_pu bit is 0, whatever the direction and data bits are.
- R6: Address 0 reads the synchronized pad level. With the default synchronizer, a pad change made just after a rising edge is still unseen after the following falling edge and is visible after the next rising edge.
- R7: The pin register also follows pins configured as outputs, so it reads back the level the port drives.
- R8: A change-flag bit sets one cycle after its synchronized pin value changes, but only if that bit's mask bit is 1. The irq output is the OR of all flag bits.
- R9: A write to address 4 clears each flag bit written 1 and keeps the bits written 0. If a new change and a clear meet in the same cycle, the flag stays set.
- R10: A pin-change flag sets on a pin configured as an output when a data write changes its level. This is the software-raised interrupt.
- R11: Addresses 5 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_we | input | 1 | Write strobe, accepted on the rising edge |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Read data for bus_addr, combinational |
| pull_disable | input | 1 | Global pull-up suppression |
| pad_in | input | WIDTH (8) | Raw pad level |
| pad_out | output | WIDTH (8) | Level driven on output pins |
| pad_oe | output | WIDTH (8) | Drive enable per pin |
| pad_pu | output | WIDTH (8) | Pull-up request per pin |
| irq | output | 1 | OR of the change flags |

## Verification
The pad-control mapping is tried with direction and data patterns that mix outputs, pulled inputs and floating inputs in one byte, with pull_disable both low and high. This separates the drive path from the pull path and shows the global override. The toggle address is written with sparse masks over bits configured both as inputs and as outputs, which shows that bits written 0 are kept and that direction has no effect. The synchronizer is probed half a cycle and one cycle after a pad edge, which pins down its latency. Pin changes are made from outside on masked and unmasked bits, and from inside through loopback. A clear write that lands in the same cycle as a new change shows that a set takes priority over a clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // Register offsets; the bench and software both depend on them.
   localparam int OFF_PIN  = 0;
   localparam int OFF_DIR  = 1;
   localparam int OFF_DATA = 2;
   localparam int OFF_MASK = 3;
   localparam int OFF_FLAG = 4;
   localparam int NUM_REGS = 5;

   typedef enum logic {
      SYNC_RISE_RISE = 1'b0,
      SYNC_FALL_RISE = 1'b1
   } sync_kind_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int                       WIDTH = 8,
   parameter gpio_bank_pkg::sync_kind_e KIND  = gpio_bank_pkg::SYNC_FALL_RISE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] synced
);
   logic [WIDTH-1:0] stage1_q;
   logic [WIDTH-1:0] stage2_q;

   generate
      if (KIND == gpio_bank_pkg::SYNC_FALL_RISE) begin : g_half
         // First stage samples on the falling edge: 0.5..1.5 cycle latency.
         always_ff @(negedge clk) begin
            if (rst) stage1_q <= '0;
            else     stage1_q <= raw;
         end
      end else begin : g_full
         always_ff @(posedge clk) begin
            if (rst) stage1_q <= '0;
            else     stage1_q <= raw;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) stage2_q <= '0;
      else     stage2_q <= stage1_q;
   end

   assign synced = stage2_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  pin_val,
   input  logic [WIDTH-1:0]  flag_val,
   output logic [WIDTH-1:0]  dir,
   output logic [WIDTH-1:0]  data,
   output logic [WIDTH-1:0]  mask,
   output logic [WIDTH-1:0]  flag_clr,
   output logic [WIDTH-1:0]  rdata
);
   localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(gpio_bank_pkg::OFF_PIN);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(gpio_bank_pkg::OFF_DIR);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(gpio_bank_pkg::OFF_DATA);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(gpio_bank_pkg::OFF_MASK);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(gpio_bank_pkg::OFF_FLAG);

   logic [WIDTH-1:0] dir_q, data_q, mask_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q  <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else if (we) begin
         case (addr)
            A_PIN:   data_q <= data_q ^ wdata;
            A_DIR:   dir_q  <= wdata;
            A_DATA:  data_q <= wdata;
            A_MASK:  mask_q <= wdata;
            default: ;
         endcase
      end
   end

   assign flag_clr = (we && addr == A_FLAG) ? wdata : '0;

   always_comb begin
      case (addr)
         A_PIN:   rdata = pin_val;
         A_DIR:   rdata = dir_q;
         A_DATA:  rdata = data_q;
         A_MASK:  rdata = mask_q;
         A_FLAG:  rdata = flag_val;
         default: rdata = '0;
      endcase
   end

   assign dir  = dir_q;
   assign data = data_q;
   assign mask = mask_q;

   // R11: unmapped addresses read zero
   always_comb begin
      if (!rst && addr >= ADDR_W'(gpio_bank_pkg::NUM_REGS))
         assert_unmapped_zero_R11: assert (rdata == '0);
   end

   // R4: a toggle write leaves the direction register alone
   assert_toggle_keeps_dir_R4: assert property (@(posedge clk) disable iff (rst)
      (we && addr == A_PIN) |=> dir_q == $past(dir_q));
endmodule

// File: rtl/gpio_bank_chg.sv
module gpio_bank_chg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] pin_val,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] flag_q;
   logic [WIDTH-1:0] hit;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= pin_val;
   end

   assign hit = (pin_val ^ prev_q) & mask;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         // A new change wins over a clear in the same cycle.
         always_ff @(posedge clk) begin
            if (rst)         flag_q[i] <= 1'b0;
            else if (hit[i]) flag_q[i] <= 1'b1;
            else if (clr[i]) flag_q[i] <= 1'b0;
         end
      end
   endgenerate

   assign flags = flag_q;

   // R8: a flag never rises on a bit whose mask was clear
   assert_flag_needs_mask_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(mask)) == '0));

   // R9: a flag drops only after a clear request
   assert_flag_drop_cleared_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int                        WIDTH  = 8,
   parameter int                        ADDR_W = 3,
   parameter gpio_bank_pkg::sync_kind_e SYNC   = gpio_bank_pkg::SYNC_FALL_RISE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic              pull_disable,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_pu,
   output logic              irq
);
   initial begin
      assert_width_ok: assert (WIDTH >= 1 && WIDTH <= 32);
      assert_addr_fits: assert ((1 << ADDR_W) >= gpio_bank_pkg::NUM_REGS);
   end

   logic [WIDTH-1:0] pin_sync, dir, data, mask, flag_clr, flags;

   gpio_bank_sync #(.WIDTH(WIDTH), .KIND(SYNC)) u_sync (
      .clk(clk), .rst(rst), .raw(pad_in), .synced(pin_sync)
   );

   gpio_bank_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .pin_val(pin_sync), .flag_val(flags), .dir(dir), .data(data),
      .mask(mask), .flag_clr(flag_clr), .rdata(bus_rdata)
   );

   gpio_bank_chg #(.WIDTH(WIDTH)) u_chg (
      .clk(clk), .rst(rst), .pin_val(pin_sync), .mask(mask),
      .clr(flag_clr), .flags(flags)
   );

   assign pad_out = data;
   assign pad_oe  = dir;
   assign pad_pu  = ~dir & data & {WIDTH{~pull_disable}};
   assign irq     = |flags;

   // R2: a data write shows on driven pins after the accepting edge
   assert_drive_follows_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == ADDR_W'(gpio_bank_pkg::OFF_DATA))
      |=> ((pad_out & pad_oe) == ($past(bus_wdata) & pad_oe)));

   // R4: toggle write inverts exactly the bits written 1
   assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == ADDR_W'(gpio_bank_pkg::OFF_PIN))
      |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

   // R5: global disable removes every pull-up request
   assert_pull_off_R5: assert property (@(posedge clk) disable iff (rst)
      pull_disable |-> pad_pu == '0);

   // R3: no pull-up is requested on a driven pin
   assert_no_pull_on_output_R3: assert property (@(posedge clk) disable iff (rst)
      (pad_pu & pad_oe) == '0);
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
   localparam int W = 8;
   localparam int A = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [A-1:0] bus_addr = '0;
   logic         bus_we = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         pull_disable = 1'b0;
   logic [W-1:0] ext = '0;
   logic [W-1:0] pad_in, pad_out, pad_oe, pad_pu;
   logic         irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   // Pad model: driven pins loop back, others take the external level.
   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   gpio_bank #(.WIDTH(W), .ADDR_W(A)) uut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pull_disable(pull_disable),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at posedge+1; ends at the next posedge+1.
   task automatic wr(input int addr, input logic [W-1:0] d);
      bus_addr = A'(addr); bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [W-1:0] d);
      bus_addr = A'(addr); #1; d = bus_rdata;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      for (int a = 0; a < 5; a++) begin
         rd(a, v); chk("R1 reg read after reset", v, '0);
      end
      chk("R1 pad_oe", pad_oe, '0);
      chk("R1 pad_pu", pad_pu, '0);
      chk("R1 irq", {7'd0, irq}, '0);
   endtask

   task automatic t_pad_map();
      wr(1, 8'hF0); wr(2, 8'hA5);
      chk("R2 pad_oe", pad_oe, 8'hF0);
      chk("R2 pad_out on outputs", pad_out & pad_oe, 8'hA0);
      chk("R3 pad_pu on inputs", pad_pu, 8'h05);
      pull_disable = 1'b1; #1;
      chk("R5 pull disable", pad_pu, 8'h00);
      pull_disable = 1'b0; #1;
      chk("R3 pull back", pad_pu, 8'h05);
   endtask

   task automatic t_toggle();
      logic [W-1:0] v;
      wr(0, 8'h81);
      rd(2, v); chk("R4 toggle data", v, 8'h24);
      wr(0, 8'h00);
      rd(2, v); chk("R4 zero toggle", v, 8'h24);
      wr(0, 8'h24);
      rd(2, v); chk("R4 toggle back", v, 8'h00);
      rd(1, v); chk("R4 dir untouched", v, 8'hF0);
   endtask

   task automatic t_sync();
      logic [W-1:0] v;
      wr(1, 8'h00); wr(2, 8'h00); step(3);
      ext = 8'h3C;
      #6;  // past the falling edge, before the rising one
      rd(0, v); chk("R6 not yet visible", v, 8'h00);
      @(posedge clk); #1;
      rd(0, v); chk("R6 visible after one rise", v, 8'h3C);
   endtask

   task automatic t_flags();
      logic [W-1:0] v;
      wr(3, 8'h0F); step(2);
      wr(4, 8'hFF);
      rd(4, v); chk("R9 clear all", v, 8'h00);
      @(posedge clk); #1;
      ext = 8'hFF;  // bits 0,1 and 6,7 change
      step(1);
      chk("R8 irq not yet", {7'd0, irq}, 8'h00);
      step(1);
      rd(4, v); chk("R8 masked flags", v, 8'h03);
      chk("R8 irq", {7'd0, irq}, 8'h01);
      wr(4, 8'h01);
      rd(4, v); chk("R9 partial clear", v, 8'h02);
      ext = 8'hFE;  // bit 0 changes; pin updates at next rise
      step(1);
      wr(4, 8'h01);  // clear lands in the same cycle as the set
      rd(4, v); chk("R9 set beats clear", v, 8'h03);
      wr(4, 8'hFF);
      chk("R9 irq low after clear", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_loopback();
      logic [W-1:0] v;
      ext = 8'h00; step(3);
      wr(4, 8'hFF);
      wr(3, 8'h10); wr(1, 8'h10);
      wr(4, 8'hFF);
      rd(4, v); chk("R10 no flag before write", v, 8'h00);
      wr(2, 8'h10);
      step(1);
      rd(0, v); chk("R7 pin reads driven value", v, 8'h10);
      step(1);
      rd(4, v); chk("R10 software flag", v, 8'h10);
      chk("R10 irq", {7'd0, irq}, 8'h01);
   endtask

   task automatic t_unmapped();
      logic [W-1:0] v;
      for (int a = 5; a < 8; a++) begin
         wr(a, 8'hFF);
         rd(a, v); chk("R11 unmapped read", v, 8'h00);
      end
      rd(1, v); chk("R11 dir kept", v, 8'h10);
      rd(2, v); chk("R11 data kept", v, 8'h10);
      rd(3, v); chk("R11 mask kept", v, 8'h10);
      rd(4, v); chk("R11 flags kept", v, 8'h10);
   endtask

   initial begin
      step(3);
      rst = 1'b0;
      t_reset();
      t_pad_map();
      t_toggle();
      t_sync();
      t_flags();
      t_loopback();
      t_unmapped();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule